// File: doc/BRIEF.md
# GF(16) Conditional Alpha-Multiply Pipeline

This block is the last step of a GF(16) multiply/divide datapath. An earlier stage produces an intermediate field element together with a two-bit count. This block multiplies that element by the primitive element alpha between zero and three times, and the outcome is the final product or quotient. Each multiply by alpha is a shift of the four-bit element with feedback from its top bit, so the feedback taps depend on the reduction polynomial. A select input chooses between x^4+x+1 and x^4+x^3+1 for each item.

The work is spread over three registered stages. Each stage compares the count it carries against its own fixed threshold and either applies one alpha step or passes the element through. The count, the polynomial select and a valid flag travel through the stages with the data. Items of any kind can therefore follow each other on consecutive cycles, and one result leaves the block every cycle. When an item's valid flag is low, its result slot is driven to zero.

Top module: `gfr_rotate_pipe`

## Requirements
- R1: While reset is asserted, and for the first three clock edges after it is released, `result` is 4'b0000.
- R2: An item presented on the inputs at a rising edge appears on `result` after exactly three rising edges, and a new item is accepted on every edge.
- R3: With `rot_cnt` = 0 the result equals `pat_in` unchanged.
- R4: With `rot_cnt` = c (0 to 3) the result equals `pat_in` multiplied by alpha^c in the selected field.
- R5: With `poly_sel` = 0 the field is x^4+x+1, and one alpha step maps bits b3..b0 to d3=b2, d2=b1, d1=b0^b3, d0=b3.
- R6: With `poly_sel` = 1 the field is x^4+x^3+1, and one alpha step maps b3..b0 to d3=b2^b3, d2=b1, d1=b0, d0=b3.
- R7: The count and the polynomial select of each item stay with that item, so changing them on the next cycle does not alter results already in flight.
- R8: An item presented with `valid_in` = 0 gives `result` = 0 three edges later, whatever its pattern, count and select.
- R9: A zero pattern gives a zero result for every count and polynomial.
- R10: Stage k (k = 1, 2, 3) applies one alpha step exactly when the item's count is greater than k-1, so an item is stepped in a prefix of the stages and never in a later stage without the earlier ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_in | input | 4 | Intermediate field element, bit 3 is the alpha^3 coefficient |
| rot_cnt | input | 2 | Number of alpha steps to apply (0 to 3) |
| poly_sel | input | 1 | 0 selects x^4+x+1, 1 selects x^4+x^3+1 |
| valid_in | input | 1 | The item on the inputs is valid |
| result | output | 4 | Final element, or zero for an invalid item |

## Verification
The main stream sends every pattern with every count under both polynomials back to back. Count zero shows the pass-through path, counts one to three show how many stages stepped, and the two polynomials tell apart the feedback taps, which only differ when bit 3 is set. A stream that alternates the select and count each cycle with the same top-bit pattern shows whether those controls stay aligned with their data. Gaps with nonzero patterns and a lone item between idle cycles pin down the zero forcing and the exact three-edge latency.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

  localparam int ELEM_W     = 4;
  localparam int CNT_W      = 2;
  localparam int NUM_STAGES = (1 << CNT_W) - 1;

  typedef logic [ELEM_W-1:0] elem_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Reduction polynomial choice
  typedef enum logic {
    POLY_X4_X_1  = 1'b0,  // x^4 + x + 1
    POLY_X4_X3_1 = 1'b1   // x^4 + x^3 + 1
  } poly_e;

  // Everything that travels through one pipeline slot
  typedef struct packed {
    elem_t data;
    cnt_t  cnt;
    poly_e poly;
    logic  vld;
  } slot_t;

  // One multiply by alpha for x^4+x+1
  function automatic elem_t step_low(elem_t b);
    elem_t d;
    d[3] = b[2];
    d[2] = b[1];
    d[1] = b[0] ^ b[3];
    d[0] = b[3];
    return d;
  endfunction

  // One multiply by alpha for x^4+x^3+1
  function automatic elem_t step_high(elem_t b);
    elem_t d;
    d[3] = b[2] ^ b[3];
    d[2] = b[1];
    d[1] = b[0];
    d[0] = b[3];
    return d;
  endfunction

endpackage

// File: rtl/gfr_alpha_step.sv
module gfr_alpha_step
  import gfr_pkg::*;
(
  input  elem_t elem_in,
  input  poly_e poly,
  output elem_t elem_out
);

  elem_t by_low;
  elem_t by_high;

  always_comb begin
    by_low  = step_low(elem_in);
    by_high = step_high(elem_in);
  end

  assign elem_out = (poly == POLY_X4_X3_1) ? by_high : by_low;

endmodule

// File: rtl/gfr_rot_stage.sv
module gfr_rot_stage
  import gfr_pkg::*;
#(
  parameter int THRESH = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t slot_in,
  output slot_t slot_out,
  output logic  take
);

  localparam cnt_t LIMIT = cnt_t'(THRESH);

  elem_t stepped;
  elem_t chosen;

  gfr_alpha_step u_step (
    .elem_in  (slot_in.data),
    .poly     (slot_in.poly),
    .elem_out (stepped)
  );

  // Comparator against this stage's own threshold
  assign take   = (slot_in.cnt > LIMIT);
  assign chosen = take ? stepped : slot_in.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_out <= '0;
    end else begin
      slot_out.data <= chosen;
      slot_out.cnt  <= slot_in.cnt;
      slot_out.poly <= slot_in.poly;
      slot_out.vld  <= slot_in.vld;
    end
  end

endmodule

// File: rtl/gfr_out_gate.sv
module gfr_out_gate
  import gfr_pkg::*;
(
  input  elem_t data_in,
  input  logic  vld_in,
  output elem_t data_out
);

  assign data_out = vld_in ? data_in : '0;

endmodule

// File: rtl/gfr_rotate_pipe.sv
module gfr_rotate_pipe
  import gfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pat_in,
  input  logic [1:0] rot_cnt,
  input  logic       poly_sel,
  input  logic       valid_in,
  output logic [3:0] result
);

  slot_t                 chain [NUM_STAGES+1];
  logic [NUM_STAGES-1:0] take_vec;

  assign chain[0].data = pat_in;
  assign chain[0].cnt  = rot_cnt;
  assign chain[0].poly = poly_e'(poly_sel);
  assign chain[0].vld  = valid_in;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    gfr_rot_stage #(
      .THRESH (g)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_in  (chain[g]),
      .slot_out (chain[g+1]),
      .take     (take_vec[g])
    );
  end

  gfr_out_gate u_gate (
    .data_in  (chain[NUM_STAGES].data),
    .vld_in   (chain[NUM_STAGES].vld),
    .data_out (result)
  );

endmodule

// File: rtl/gfr_rotate_chk.sv
module gfr_rotate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] pat_in,
  input logic [1:0] rot_cnt,
  input logic       poly_sel,
  input logic       valid_in,
  input logic [3:0] result,
  input logic [2:0] take_vec
);

  // Edges seen since reset release, saturating at 3
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  // Shift-and-reduce reference, written independently of the stage logic
  function automatic logic [3:0] chk_ref(logic [3:0] p, logic [1:0] c, logic s);
    logic [4:0] acc;
    acc = {1'b0, p};
    for (int i = 0; i < 3; i++) begin
      if (i < int'(c)) begin
        acc = {acc[3:0], 1'b0};
        if (acc[4]) acc = acc ^ (s ? 5'b11001 : 5'b10011);
      end
    end
    return acc[3:0];
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd3) |-> (result == 4'd0));

  assert_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(valid_in, 3) && $past(rot_cnt, 3) == 2'd0)
      |-> (result == $past(pat_in, 3)));

  assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(valid_in, 3))
      |-> (result == chk_ref($past(pat_in, 3), $past(rot_cnt, 3), $past(poly_sel, 3))));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(valid_in, 3)) |-> (result == 4'd0));

  assert_stage2_after_stage1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && take_vec[1]) |-> $past(take_vec[0]));

  assert_stage3_after_stage2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && take_vec[2]) |-> $past(take_vec[1]));

endmodule

bind gfr_rotate_pipe gfr_rotate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pat_in   (pat_in),
  .rot_cnt  (rot_cnt),
  .poly_sel (poly_sel),
  .valid_in (valid_in),
  .result   (result),
  .take_vec (take_vec)
);

// File: tb/gfr_rotate_pipe_test.sv
`timescale 1ns/1ps
module gfr_rotate_pipe_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pat_in = '0;
  logic [1:0] rot_cnt = '0;
  logic       poly_sel = 1'b0;
  logic       valid_in = 1'b0;
  logic [3:0] result;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [3:0] s_pat [0:255];
  logic [1:0] s_cnt [0:255];
  logic       s_sel [0:255];
  logic       s_vld [0:255];

  always #2.5 clk = ~clk;

  gfr_rotate_pipe uut (
    .clk(clk), .rst_n(rst_n), .pat_in(pat_in), .rot_cnt(rot_cnt),
    .poly_sel(poly_sel), .valid_in(valid_in), .result(result)
  );

  // Polynomial product pat * x^cnt reduced modulo the chosen polynomial
  function automatic logic [3:0] model(logic [3:0] p, logic [1:0] c, logic s);
    logic [7:0] v;
    logic [7:0] poly;
    v = {4'b0, p} << c;
    poly = s ? 8'h19 : 8'h13;
    for (int b = 6; b >= 4; b--) if (v[b]) v = v ^ (poly << (b - 4));
    return v[3:0];
  endfunction

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(logic [3:0] p, logic [1:0] c, logic s, logic v);
    pat_in = p; rot_cnt = c; poly_sel = s; valid_in = v;
  endtask

  // Streams n prepared items back to back, checking each three edges later
  task automatic run_stream(int n, string req);
    for (int t = 0; t < n + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        int k = t - 3;
        string tag;
        tag = req;
        if (s_vld[k] && s_cnt[k] == 0) tag = {tag, " R3"};
        if (s_vld[k] && s_pat[k] == 0) tag = {tag, " R9"};
        if (s_vld[k] && s_cnt[k] != 0) tag = {tag, s_sel[k] ? " R6" : " R5"};
        check(tag, result, s_vld[k] ? model(s_pat[k], s_cnt[k], s_sel[k]) : 4'd0);
      end
      if (t < n) drive(s_pat[t], s_cnt[t], s_sel[t], s_vld[t]);
      else drive(4'd0, 2'd0, 1'b0, 1'b0);
    end
  endtask

  task automatic test_reset();
    // R1: junk valid items during reset must not show
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      drive(4'(i + 9), 2'(i), i[0], 1'b1);
      check("R1 in reset", result, 4'd0);
    end
    @(negedge clk);
    drive(4'd0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 after release", result, 4'd0);
    end
  endtask

  task automatic test_latency();
    // R2: lone item, output only on the third edge
    @(negedge clk);
    drive(4'b1011, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    drive(4'd0, 2'd0, 1'b0, 1'b0);
    check("R2 edge1", result, 4'd0);
    @(negedge clk);
    check("R2 edge2", result, 4'd0);
    @(negedge clk);
    check("R2 edge3", result, model(4'b1011, 2'd2, 1'b0));
    @(negedge clk);
    check("R2 edge4", result, 4'd0);
  endtask

  task automatic test_sweep();
    // R4 R10 R2: all patterns, counts and polynomials back to back
    for (int i = 0; i < 128; i++) begin
      s_pat[i] = 4'(i);
      s_cnt[i] = 2'(i >> 4);
      s_sel[i] = i[6];
      s_vld[i] = 1'b1;
    end
    run_stream(128, "R4 R10 R2");
  endtask

  task automatic test_interleave();
    // R7: select and count flip every cycle with a top-bit pattern
    for (int i = 0; i < 12; i++) begin
      s_pat[i] = (i % 3 == 0) ? 4'b1000 : 4'b1101;
      s_cnt[i] = 2'((i * 3 + 1) % 4);
      s_sel[i] = i[0];
      s_vld[i] = 1'b1;
    end
    run_stream(12, "R7");
  endtask

  task automatic test_gaps();
    // R8: invalid items with nonzero data interleaved with valid ones
    for (int i = 0; i < 16; i++) begin
      s_pat[i] = 4'(15 - i) | 4'b1000;
      s_cnt[i] = 2'd3;
      s_sel[i] = i[1];
      s_vld[i] = (i % 3 == 1);
    end
    run_stream(16, "R8");
  endtask

  initial begin
    test_reset();
    test_latency();
    test_sweep();
    test_interleave();
    test_gaps();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R2 watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule